// File: doc/BRIEF.md
# Dual Register-Set Task Scheduler

This controller decides which of two scaler programming sets, called task A and task B, drives the scaler datapath, and when. Each set carries its own enable, start-condition code, repeat flag, field-skip count and first-line offset. From the datapath the scheduler receives a vertical-sync pulse, the field identifier, the current line number and a pulse that marks the end of a task. It drives back a task select, a level that is high while the chosen task is processing, and a toggle flag that lets downstream logic tell odd from even task activations. The toggle is used when a reduced-rate interlaced picture is rebuilt.

A task moves through three steps. First the scheduler chooses it. Then it waits out the task's field-skip count, one step per vertical sync. Then it waits for the task's start condition at the task's line offset, and the task runs until the end pulse arrives. Only the chosen task's condition is watched. A task reached after its offset line has passed in the current field therefore waits for that line in a later field. After a hardware or software reset, task B is preferred. After that the two tasks alternate, with an optional single repeat of each. A task that is the only one enabled is reused.

The block carries no data stream, so there is no valid/ready handshake. Every pin is a plain control level or a single-cycle pulse sampled on the rising clock edge.

Top module: `task_pair_sched`

## Requirements
- R1: While rst_n is low, and at the first edge after its release, task_sel is 1 (task B), proc_active is 0 and toggle is 0.
- R2: Start-condition code (per task, 2 bits). In every case the task starts only in a cycle where line_cnt equals its offset. Code 0 starts at the first such cycle. Code 1 additionally needs a vsync seen since the task was armed. Code 2 needs fid = 0 in that cycle. Code 3 needs fid = 1 in that cycle. proc_active rises one cycle after the qualifying cycle.
- R3: When task_done ends a task and the other task is enabled, the other task is selected on the next edge (task_sel 0 = A, 1 = B).
- R4: A task whose repeat bit is 1 is selected once more after it ends. It then hands over to the other enabled task, so with both repeat bits set the order is B,B,A,A,B,B...
- R5: With a skip count s > 0, the task is armed only after s vsync pulses have been counted after its selection. With s = 0, it is armed at once.
- R6: Enable bits are sampled only when a task is chosen. Changing them while a task runs keeps proc_active high until task_done.
- R7: sw_rst_n low forces, at the next edge, proc_active 0, task_sel 1 and toggle 0, whatever the current state.
- R8: toggle inverts in exactly the cycle proc_active rises and holds at all other times, so it is 1 after odd-numbered activations and 0 after even ones.
- R9: With both enables 0 the scheduler stays idle, proc_active stays 0 and toggle holds. With only one enable set, that task is selected for every activation.
- R10: task_done is ignored unless a task is processing: it neither changes task_sel nor starts anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst_n | input | 1 | Synchronous software reset, active low |
| a_en | input | 1 | Task A enable |
| a_mode | input | 2 | Task A start-condition code (see R2) |
| a_rpt | input | 1 | Task A repeat flag |
| a_skip | input | SKIP_W | Task A vsync count before arming |
| a_voff | input | LINE_W | Task A start line |
| b_en | input | 1 | Task B enable |
| b_mode | input | 2 | Task B start-condition code |
| b_rpt | input | 1 | Task B repeat flag |
| b_skip | input | SKIP_W | Task B vsync count before arming |
| b_voff | input | LINE_W | Task B start line |
| vsync | input | 1 | Vertical-sync pulse, one cycle per field |
| fid | input | 1 | Field identifier |
| line_cnt | input | LINE_W | Current line number |
| task_done | input | 1 | End-of-task pulse from the datapath |
| task_sel | output | 1 | Selected task, 0 = A, 1 = B |
| proc_active | output | 1 | High while the selected task processes |
| toggle | output | 1 | Activation parity flag |

## Verification
A wrong skip count or a lost armed-vsync flag shows up at once as proc_active rising in the wrong field. An error of one vsync therefore moves the start by a whole field, and a line comparison off by one moves the start line. Faults in task choice, such as a repeat not taken or a disabled task picked, appear one edge after task_done on task_sel and again at the next start. Toggle parity faults are visible at every activation. A software reset that fails to reach every register shows one edge later on all three outputs.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_ARM  = 2'd2,
    ST_RUN  = 2'd3
  } sched_state_t;

  localparam logic [1:0] START_NOW  = 2'd0;
  localparam logic [1:0] START_VS   = 2'd1;
  localparam logic [1:0] START_FID0 = 2'd2;
  localparam logic [1:0] START_FID1 = 2'd3;

  localparam int NUM_TASKS = 2;
  localparam logic TASK_A = 1'b0;
  localparam logic TASK_B = 1'b1;
endpackage

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
(
  input  logic [NUM_TASKS-1:0] en,
  input  logic [NUM_TASKS-1:0] rpt,
  input  logic                 cur,
  input  logic                 rep_done,
  input  logic                 from_idle,
  output logic                 ok,
  output logic                 nxt,
  output logic                 nxt_rep
);
  always_comb begin
    ok      = 1'b0;
    nxt     = cur;
    nxt_rep = 1'b0;
    if (from_idle) begin
      ok  = |en;
      nxt = en[TASK_B] ? TASK_B : TASK_A;
    end else if (en[cur] && rpt[cur] && !rep_done) begin
      ok      = 1'b1;
      nxt     = cur;
      nxt_rep = 1'b1;
    end else if (en[~cur]) begin
      ok  = 1'b1;
      nxt = ~cur;
    end else if (en[cur]) begin
      ok  = 1'b1;
      nxt = cur;
    end
  end
endmodule

// File: rtl/sched_skip_ctr.sv
module sched_skip_ctr #(
  parameter int SKIP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [SKIP_W-1:0] load_val,
  input  logic              dec,
  output logic [SKIP_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - SKIP_W'(1);
  end

  // R5: the top only counts down while fields remain to be skipped
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !load) |-> (cnt != '0));
endmodule

// File: rtl/sched_trig.sv
module sched_trig
  import sched_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              arm,
  input  logic              vsync,
  input  logic              fid,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [1:0]        mode,
  input  logic [LINE_W-1:0] voff,
  output logic              fire
);
  logic vs_seen;
  logic at_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             vs_seen <= 1'b0;
    else if (clr)           vs_seen <= 1'b0;
    else if (arm && vsync)  vs_seen <= 1'b1;
  end

  assign at_line = (line_cnt == voff);

  always_comb begin
    fire = 1'b0;
    if (arm && at_line) begin
      case (mode)
        START_NOW:  fire = 1'b1;
        START_VS:   fire = vs_seen;
        START_FID0: fire = !fid;
        default:    fire = fid;
      endcase
    end
  end

  // R2: a vsync-qualified start never happens without an armed vsync
  assert_vs_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == START_VS) |-> vs_seen);
endmodule

// File: rtl/task_pair_sched.sv
module task_pair_sched
  import sched_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int SKIP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst_n,
  input  logic              a_en,
  input  logic [1:0]        a_mode,
  input  logic              a_rpt,
  input  logic [SKIP_W-1:0] a_skip,
  input  logic [LINE_W-1:0] a_voff,
  input  logic              b_en,
  input  logic [1:0]        b_mode,
  input  logic              b_rpt,
  input  logic [SKIP_W-1:0] b_skip,
  input  logic [LINE_W-1:0] b_voff,
  input  logic              vsync,
  input  logic              fid,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              task_done,
  output logic              task_sel,
  output logic              proc_active,
  output logic              toggle
);
  localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(1);

  logic [NUM_TASKS-1:0]             en_v, rpt_v;
  logic [NUM_TASKS-1:0][1:0]        mode_v;
  logic [NUM_TASKS-1:0][SKIP_W-1:0] skip_v;
  logic [NUM_TASKS-1:0][LINE_W-1:0] voff_v;

  assign en_v      = {b_en, a_en};
  assign rpt_v     = {b_rpt, a_rpt};
  assign mode_v[0] = a_mode;
  assign mode_v[1] = b_mode;
  assign skip_v[0] = a_skip;
  assign skip_v[1] = b_skip;
  assign voff_v[0] = a_voff;
  assign voff_v[1] = b_voff;

  sched_state_t      state;
  logic              cur, rep_done, tog_q;
  logic              pick_ok, pick_nxt, pick_rep;
  logic              choose, load_evt, fire;
  logic [SKIP_W-1:0] load_val, skip_cnt;

  sched_pick u_pick (
    .en        (en_v),
    .rpt       (rpt_v),
    .cur       (cur),
    .rep_done  (rep_done),
    .from_idle (state == ST_IDLE),
    .ok        (pick_ok),
    .nxt       (pick_nxt),
    .nxt_rep   (pick_rep)
  );

  assign choose   = (state == ST_IDLE) || (state == ST_RUN && task_done);
  assign load_evt = choose && pick_ok && sw_rst_n;
  assign load_val = skip_v[pick_nxt];

  sched_skip_ctr #(.SKIP_W(SKIP_W)) u_skip (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!sw_rst_n),
    .load     (load_evt),
    .load_val (load_val),
    .dec      (state == ST_SKIP && vsync),
    .cnt      (skip_cnt)
  );

  sched_trig #(.LINE_W(LINE_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load_evt || !sw_rst_n),
    .arm      (state == ST_ARM),
    .vsync    (vsync),
    .fid      (fid),
    .line_cnt (line_cnt),
    .mode     (mode_v[cur]),
    .voff     (voff_v[cur]),
    .fire     (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur      <= TASK_B;
      rep_done <= 1'b0;
      tog_q    <= 1'b0;
    end else if (!sw_rst_n) begin
      state    <= ST_IDLE;
      cur      <= TASK_B;
      rep_done <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      case (state)
        ST_SKIP: if (vsync && skip_cnt == SKIP_LAST) state <= ST_ARM;
        ST_ARM: if (fire) begin
          state <= ST_RUN;
          tog_q <= ~tog_q;
        end
        default: begin
          if (choose) begin
            if (pick_ok) begin
              cur      <= pick_nxt;
              rep_done <= pick_rep;
              state    <= (load_val == '0) ? ST_ARM : ST_SKIP;
            end else begin
              state    <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign task_sel    = cur;
  assign proc_active = (state == ST_RUN);
  assign toggle      = tog_q;

  // R7: software reset reaches every output one edge later
  assert_swrst_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst_n |=> (!proc_active && task_sel && !toggle));

  // R6: a running task only ends through task_done or software reset
  assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_active && !task_done && sw_rst_n) |=> proc_active);

  // R8: toggle changes exactly when processing begins
  assert_toggle_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_n |=> ((toggle != $past(toggle)) == $rose(proc_active)));

  // R2: processing begins only after the task's offset line was present
  assert_start_at_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proc_active) |-> ($past(line_cnt) == voff_v[cur]));

  // R9: with nothing enabled the scheduler does not leave idle
  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && en_v == '0 && sw_rst_n) |=> (state == ST_IDLE));

  // R10: outside processing, task_done cannot move the selection
  assert_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst_n && (state == ST_SKIP || state == ST_ARM)) |=> (task_sel == $past(task_sel)));
endmodule

// File: tb/tb_task_pair_sched.sv
module tb_task_pair_sched;
  localparam int LW = 10;
  localparam int SW = 3;
  localparam int NLINES = 16;
  localparam int DONE_LN = 10;

  logic clk = 1'b0, rst_n = 1'b0, sw_rst_n = 1'b1;
  logic a_en = 0, a_rpt = 0, b_en = 0, b_rpt = 0;
  logic [1:0] a_mode = 0, b_mode = 0;
  logic [SW-1:0] a_skip = 0, b_skip = 0;
  logic [LW-1:0] a_voff = 0, b_voff = 0;
  logic vsync = 0, fid = 0, task_done = 0;
  logic [LW-1:0] line_cnt = 0;
  logic task_sel, proc_active, toggle;

  task_pair_sched #(.LINE_W(LW), .SKIP_W(SW)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int field_idx = -1;
  int n_starts = 0;
  bit auto_done = 0;
  int st_field[16], st_line[16], st_sel[16], st_tog[16];
  logic prev_act = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
    #2;
    if (proc_active && !prev_act && n_starts < 16) begin
      st_field[n_starts] = field_idx;
      st_line[n_starts]  = int'(line_cnt);
      st_sel[n_starts]   = int'(task_sel);
      st_tog[n_starts]   = int'(toggle);
      n_starts++;
    end
    prev_act = proc_active;
  end

  task automatic run_field(input bit f);
    @(negedge clk);
    vsync = 1; line_cnt = 0; fid = f; field_idx++;
    @(negedge clk);
    vsync = 0;
    for (int ln = 0; ln < NLINES; ln++) begin
      line_cnt = LW'(ln);
      if (auto_done && proc_active && ln == DONE_LN) task_done = 1;
      @(negedge clk);
      task_done = 0;
      @(negedge clk);
    end
    line_cnt = 0;
  endtask

  task automatic soft_reset();
    @(negedge clk);
    sw_rst_n = 0;
    @(negedge clk);
    sw_rst_n = 1; n_starts = 0; field_idx = -1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_done();
    task_done = 1;
    @(negedge clk);
    task_done = 0;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset values
    @(negedge clk); @(negedge clk);
    chk("R1 sel in reset", int'(task_sel), 1);
    chk("R1 active in reset", int'(proc_active), 0);
    chk("R1 toggle in reset", int'(toggle), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sel after release", int'(task_sel), 1);
    chk("R9 idle active", int'(proc_active), 0);

    // Sweep 1: start code x skip count on task B (R2, R5, R8)
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 8; s++) begin
        int base, expf;
        auto_done = 0;
        b_en = 1; a_en = 0; b_rpt = 0; b_mode = 2'(m); b_skip = SW'(s); b_voff = 5;
        soft_reset();
        base = (s == 0) ? 0 : s - 1;
        if (m == 1) base = s;
        expf = base;
        if (m == 2) expf = base + (base % 2);
        if (m == 3) expf = base + 1 - (base % 2);
        for (int k = 0; k <= expf + 1; k++) run_field(k[0]);
        chk($sformatf("R5 R2 starts m=%0d s=%0d", m, s), n_starts, 1);
        chk($sformatf("R5 R2 field m=%0d s=%0d", m, s), st_field[0], expf);
        chk($sformatf("R2 line m=%0d s=%0d", m, s), st_line[0], 5);
        chk($sformatf("R8 toggle m=%0d s=%0d", m, s), st_tog[0], 1);
      end
    end

    // Sweep 2: enables x repeat bits (R3, R4, R8, R9)
    for (int e = 0; e < 4; e++) begin
      for (int r = 0; r < 4; r++) begin
        int cur_e, repd, exp_n;
        bit [1:0] env, rv;
        env = 2'(e); rv = 2'(r);
        a_en = env[0]; b_en = env[1]; a_rpt = rv[0]; b_rpt = rv[1];
        a_mode = 0; b_mode = 0; a_skip = 0; b_skip = 0; a_voff = 3; b_voff = 3;
        auto_done = 1;
        soft_reset();
        for (int k = 0; k < 6; k++) run_field(k[0]);
        exp_n = (e == 0) ? 0 : 6;
        chk($sformatf("R9 starts en=%0d rpt=%0d", e, r), n_starts, exp_n);
        if (e == 0) chk("R9 toggle held", int'(toggle), 0);
        cur_e = 0; repd = 0;
        for (int k = 0; k < exp_n; k++) begin
          if (k == 0) begin
            cur_e = env[1] ? 1 : 0; repd = 0;
          end else if (env[cur_e] && rv[cur_e] && repd == 0) begin
            repd = 1;
          end else if (env[1 - cur_e]) begin
            cur_e = 1 - cur_e; repd = 0;
          end else begin
            repd = 0;
          end
          chk($sformatf("R3 R4 sel en=%0d rpt=%0d k=%0d", e, r, k), st_sel[k], cur_e);
          chk($sformatf("R8 tog en=%0d rpt=%0d k=%0d", e, r, k), st_tog[k], (k + 1) % 2);
        end
      end
    end

    // Directed: R6, R10, R7
    auto_done = 0;
    a_rpt = 0; b_rpt = 0; a_en = 0; b_en = 1; a_voff = 3; b_voff = 3;
    soft_reset();
    run_field(0);
    chk("R6 B running", int'(proc_active), 1);
    a_en = 1; b_en = 0;
    run_field(1);
    chk("R6 still running after enable change", int'(proc_active), 1);
    chk("R6 sel kept", int'(task_sel), 1);
    pulse_done();
    chk("R3 A selected after done", int'(task_sel), 0);
    chk("R3 not active", int'(proc_active), 0);
    b_en = 1;
    pulse_done();
    chk("R10 done ignored while waiting", int'(task_sel), 0);
    run_field(0);
    chk("R10 A starts", int'(proc_active), 1);
    chk("R10 A sel", int'(task_sel), 0);
    chk("R8 toggle after second start", int'(toggle), 0);
    pulse_done();
    chk("R3 B after A", int'(task_sel), 1);
    run_field(1);
    chk("R8 toggle after third start", int'(toggle), 1);
    @(negedge clk);
    sw_rst_n = 0;
    @(negedge clk);
    chk("R7 active cleared", int'(proc_active), 0);
    chk("R7 sel to B", int'(task_sel), 1);
    chk("R7 toggle cleared", int'(toggle), 0);
    sw_rst_n = 1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule